// File: doc/BRIEF.md
# DRAM Command Request Chooser

This block sits between a set of per-bank command sources and a single command lane of a DRAM controller. Each source offers one command request: a valid flag, row or column address, bank number, the three strobe bits (cas, ras, we) and three kind flags (non-data command, read, write). Four enable inputs choose which kinds may win in the current cycle: reads, writes, non-data commands, and activates as a further gate on non-data commands. The controller's sequencer drives these enables to steer the lane between read bursts, write bursts and bank management.

A registered round-robin pointer names the chosen request. The chosen request's fields appear on the output command combinationally. The pointer moves to the next eligible index, in increasing order with wrap-around, after every cycle in which the output is either not valid or taken (valid and ready together). So a winner keeps the lane while it stalls, and loses it as soon as it withdraws. Decode outputs flag whether the chosen command is a read, a write or an activate. A per-input ready returns the handshake to the source that won.

Top module: `dram_cmd_picker`

## Requirements
- R1: A request is eligible when its valid is high and at least one of these holds: is_read is high with rd_en set, is_write is high with wr_en set, or is_cmd is high with cmd_en set.
- R2: An activate (ras=1, cas=0, we=0 with is_cmd) is eligible only when cmd_en and act_en are both set. With act_en alone set, nothing is chosen.
- R3: When no request is eligible, cmd_valid is 0 and cmd_cas, cmd_ras and cmd_we are all 0.
- R4: While cmd_valid is high and cmd_ready is low, the chosen index does not change.
- R5: After a clock edge at which cmd_valid and cmd_ready are both high, the chosen index becomes the nearest eligible index above the current one. The search wraps from NREQ-1 to 0, and slots that are invalid or not enabled are skipped.
- R6: After a clock edge at which the chosen request is not eligible (for example, its valid was dropped), the chosen index moves to the next eligible index in the same way.
- R7: cmd_accept equals cmd_valid AND cmd_ready. req_ready has at most one bit set: the chosen index's bit, set only while cmd_accept is high.
- R8: The decode outputs look at the chosen request's strobes whether or not it is eligible. is_rd is cas only (cas=1, ras=0, we=0). is_wr is cas and we (cas=1, ras=0, we=1). is_act is ras only (ras=1, cas=0, we=0). Any other strobe pattern gives all three low.
- R9: Reset sets the chosen index to 0.
- R10: While cmd_valid is high, cmd_addr and cmd_bank carry the chosen request's address and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Reads may win |
| wr_en | input | 1 | Writes may win |
| cmd_en | input | 1 | Non-data commands may win |
| act_en | input | 1 | Activates may win (also needs cmd_en) |
| req_valid | input | NREQ | Request valid per source |
| req_addr | input | NREQ x AW | Address per source |
| req_bank | input | NREQ x BW | Bank per source |
| req_cas | input | NREQ | cas strobe per source |
| req_ras | input | NREQ | ras strobe per source |
| req_we | input | NREQ | we strobe per source |
| req_is_cmd | input | NREQ | Non-data command flag per source |
| req_is_read | input | NREQ | Read flag per source |
| req_is_write | input | NREQ | Write flag per source |
| req_ready | output | NREQ | Handshake back to the winning source |
| cmd_valid | output | 1 | Output command valid |
| cmd_ready | input | 1 | Output command taken |
| cmd_addr | output | AW | Chosen address |
| cmd_bank | output | BW | Chosen bank |
| cmd_cas | output | 1 | Chosen cas, 0 when not valid |
| cmd_ras | output | 1 | Chosen ras, 0 when not valid |
| cmd_we | output | 1 | Chosen we, 0 when not valid |
| cmd_is_cmd | output | 1 | Chosen non-data flag, 0 when not valid |
| cmd_is_read | output | 1 | Chosen read flag, 0 when not valid |
| cmd_is_write | output | 1 | Chosen write flag, 0 when not valid |
| is_rd | output | 1 | Chosen strobes decode as read |
| is_wr | output | 1 | Chosen strobes decode as write |
| is_act | output | 1 | Chosen strobes decode as activate |
| cmd_accept | output | 1 | Handshake this cycle |

## Verification
The command outputs, the decode outputs and cmd_accept are combinational from the inputs and the pointer, so they are due in the same cycle as the stimulus. The bench samples them on the falling edge after the inputs settle. The pointer is the only register, so a handshake or a dropped valid shows up as a new chosen index exactly one rising edge later. The bench therefore raises cmd_ready or drops a valid for exactly one rising edge and checks on the following falling edge. In the stall cases, several such edges pass with cmd_ready low before the index is checked again.

// File: rtl/dram_cmd_picker.sv
module dram_cmd_picker #(
  parameter int NREQ = 8,
  parameter int AW   = 13,
  parameter int BW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic                     cmd_en,
  input  logic                     act_en,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ-1:0][AW-1:0]  req_addr,
  input  logic [NREQ-1:0][BW-1:0]  req_bank,
  input  logic [NREQ-1:0]          req_cas,
  input  logic [NREQ-1:0]          req_ras,
  input  logic [NREQ-1:0]          req_we,
  input  logic [NREQ-1:0]          req_is_cmd,
  input  logic [NREQ-1:0]          req_is_read,
  input  logic [NREQ-1:0]          req_is_write,
  output logic [NREQ-1:0]          req_ready,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic [AW-1:0]            cmd_addr,
  output logic [BW-1:0]            cmd_bank,
  output logic                     cmd_cas,
  output logic                     cmd_ras,
  output logic                     cmd_we,
  output logic                     cmd_is_cmd,
  output logic                     cmd_is_read,
  output logic                     cmd_is_write,
  output logic                     is_rd,
  output logic                     is_wr,
  output logic                     is_act,
  output logic                     cmd_accept
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IW-1:0]   grant, grant_nxt;
  logic [NREQ-1:0] elig;
  logic            s_cas, s_ras, s_we;

  for (genvar g = 0; g < NREQ; g++) begin : g_slot
    logic act_kind;
    assign act_kind  = req_ras[g] & ~req_cas[g] & ~req_we[g];
    assign elig[g]   = req_valid[g] &
                       ((req_is_read[g] & rd_en) |
                        (req_is_write[g] & wr_en) |
                        (req_is_cmd[g] & cmd_en & (~act_kind | act_en)));
    assign req_ready[g] = cmd_accept & (grant == IW'(g));
  end

  always_comb begin
    logic [IW:0] t;
    grant_nxt = grant;
    for (int k = NREQ; k >= 1; k--) begin
      t = {1'b0, grant} + (IW+1)'(k);
      if (t >= (IW+1)'(NREQ)) t = t - (IW+1)'(NREQ);
      if (elig[t[IW-1:0]]) grant_nxt = t[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       grant <= '0;
    else if (!cmd_valid || cmd_ready) grant <= grant_nxt;
  end

  assign s_cas = req_cas[grant];
  assign s_ras = req_ras[grant];
  assign s_we  = req_we[grant];

  assign cmd_valid    = elig[grant];
  assign cmd_addr     = req_addr[grant];
  assign cmd_bank     = req_bank[grant];
  assign cmd_cas      = cmd_valid & s_cas;
  assign cmd_ras      = cmd_valid & s_ras;
  assign cmd_we       = cmd_valid & s_we;
  assign cmd_is_cmd   = cmd_valid & req_is_cmd[grant];
  assign cmd_is_read  = cmd_valid & req_is_read[grant];
  assign cmd_is_write = cmd_valid & req_is_write[grant];
  assign is_rd        =  s_cas & ~s_ras & ~s_we;
  assign is_wr        =  s_cas & ~s_ras &  s_we;
  assign is_act       = ~s_cas &  s_ras & ~s_we;
  assign cmd_accept   = cmd_valid & cmd_ready;

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> grant == $past(grant));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && $countones(elig) > 1) |=> grant != $past(grant));

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && (req_ready == '0 || cmd_ready));

  a_r2_act_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_act && !cmd_is_read && !cmd_is_write) |-> (cmd_en && act_en));

  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !(cmd_cas || cmd_ras || cmd_we || cmd_accept));
endmodule

// File: tb/dram_cmd_picker_test.sv
module dram_cmd_picker_test;
  localparam int N = 8, AW = 13, BW = 3;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0, cmd_en = 0, act_en = 0;
  logic [N-1:0] req_valid = '0, req_cas = '0, req_ras = '0, req_we = '0;
  logic [N-1:0] req_is_cmd = '0, req_is_read = '0, req_is_write = '0;
  logic [N-1:0][AW-1:0] req_addr;
  logic [N-1:0][BW-1:0] req_bank;
  logic [N-1:0] req_ready;
  logic cmd_valid, cmd_ready = 0, cmd_cas, cmd_ras, cmd_we;
  logic cmd_is_cmd, cmd_is_read, cmd_is_write, is_rd, is_wr, is_act, cmd_accept;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] cmd_bank;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cmd_picker #(.NREQ(N), .AW(AW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .cmd_en(cmd_en), .act_en(act_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_bank(req_bank), .req_cas(req_cas),
    .req_ras(req_ras), .req_we(req_we), .req_is_cmd(req_is_cmd), .req_is_read(req_is_read),
    .req_is_write(req_is_write), .req_ready(req_ready), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_cas(cmd_cas),
    .cmd_ras(cmd_ras), .cmd_we(cmd_we), .cmd_is_cmd(cmd_is_cmd), .cmd_is_read(cmd_is_read),
    .cmd_is_write(cmd_is_write), .is_rd(is_rd), .is_wr(is_wr), .is_act(is_act),
    .cmd_accept(cmd_accept));

  // patterns: one char per slot, slot 0 leftmost; wants = {rd, wr, cmd, act}
  localparam logic [63:0] PATS  [8] = '{"w_rawpwr", "w_rawpwr", "rp_awrrw", "rp_awrrw",
                                        "pr_aa_pw", "pr_aa_pw", "pr_aa_pw", "pr_aa_pw"};
  localparam logic [3:0]  WANTS [8] = '{4'b0000, 4'b0100, 4'b1000, 4'b1100,
                                        4'b0010, 4'b0011, 4'b0001, 4'b0110};
  localparam logic [63:0] ORDS  [8] = '{"________", "04604604", "05605605", "04567045",
                                        "06060606", "03460346", "________", "06706706"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input logic [7:0] c);
    req_valid[i] = (c != "_");
    req_cas[i] = (c == "r" || c == "w" || c == "f");
    req_ras[i] = (c == "a" || c == "p" || c == "f");
    req_we[i]  = (c == "w" || c == "p");
    req_is_read[i]  = (c == "r");
    req_is_write[i] = (c == "w");
    req_is_cmd[i]   = (c == "a" || c == "p" || c == "f");
    req_addr[i] = AW'(i);
    req_bank[i] = BW'(i);
  endtask

  task automatic set_pat(input logic [63:0] p);
    for (int i = 0; i < N; i++) set_slot(i, p[63-8*i -: 8]);
  endtask

  task automatic set_wants(input logic [3:0] w);
    {rd_en, wr_en, cmd_en, act_en} = w;
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_ready = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_ready();
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_pat("________");
    do_reset();

    // R9 reset state: all slots valid precharges, cmds wanted -> index 0
    set_pat("pppppppp"); set_wants(4'b0010);
    @(negedge clk);
    check("R9 reset index", cmd_bank, 0);
    check("R10 addr of chosen", cmd_addr, 0);

    // R4 stall holds
    repeat (3) @(negedge clk);
    check("R4 stall keeps index", cmd_bank, 0);

    // R7 accept and ready return
    cmd_ready = 1; #1;
    check("R7 accept high", cmd_accept, 1);
    check("R7 req_ready one-hot", req_ready, 1);
    @(negedge clk); cmd_ready = 0; #1;
    check("R7 accept low without ready", cmd_accept, 0);
    check("R7 req_ready idle", req_ready, 0);
    check("R5 advance after handshake", cmd_bank, 1);

    // R6 dropped valid moves the pointer
    req_valid[1] = 0;
    @(negedge clk);
    req_valid[1] = 1; #1;
    check("R6 advance on dropped valid", cmd_bank, 2);

    // R8 decode ignores eligibility
    do_reset(); set_wants(4'b0000);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] c;
      c = (k == 0) ? "r" : (k == 1) ? "w" : (k == 2) ? "a" : "p";
      set_slot(0, c);
      @(negedge clk);
      check("R8 is_rd", is_rd, (k == 0) ? 1 : 0);
      check("R8 is_wr", is_wr, (k == 1) ? 1 : 0);
      check("R8 is_act", is_act, (k == 2) ? 1 : 0);
    end

    // R3 accept stays low with nothing eligible
    cmd_ready = 1; #1;
    check("R3 no valid", cmd_valid, 0);
    check("R3 no accept", cmd_accept, 0);
    cmd_ready = 0;

    // R1 R2 R3 R5 order table
    for (int e = 0; e < 8; e++) begin
      set_pat(PATS[e]); set_wants(WANTS[e]);
      do_reset();
      @(negedge clk);
      for (int s = 0; s < 8; s++) begin
        logic [7:0] o;
        o = ORDS[e][63-8*s -: 8];
        if (o == "_") begin
          check("R2 R3 nothing chosen valid", cmd_valid, 0);
          check("R3 strobes zero", {cmd_cas, cmd_ras, cmd_we}, 0);
        end else begin
          check("R1 chosen valid", cmd_valid, 1);
          check("R5 R1 order bank", cmd_bank, o - "0");
        end
        pulse_ready();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule